// File: doc/BRIEF.md
# Round-Robin Fully Associative Read Cache

This block is a small read-only cache. Any word address can sit in any of its `LINES` lines, and the whole word address serves as the tag. It takes at most one word-addressed read per cycle. When the address is already held, the cached word and a hit flag come back in the same cycle. When the address is absent, the block raises a request on a simple memory port and holds it until an acknowledge brings the word. In that acknowledge cycle it stores the word and also returns it to the requester, flagged as a miss.

A single round-robin pointer chooses which line to overwrite. The pointer moves only when a line is really overwritten, and lookups that hit leave it alone. An empty cache fills from the lowest index up, and the pointer stays at line 0 throughout that fill. The result is strict first-in-first-out eviction by install order. Two saturating counters tally hits and misses so that a steady-state miss rate can be read off. A synchronous clear input zeroes both counters.

The controller is a two-state machine. `ST_IDLE` accepts requests. A hit stays in `ST_IDLE`, and an accepted miss moves to `ST_FETCH`. `ST_FETCH` holds the memory request and returns to `ST_IDLE` on `mem_ack`.

Top module: `fa_rr_cache`

## Requirements
- R1: After reset no line holds valid data, both counters read 0, `req_ready` is 1, and `mem_req` and `resp_valid` are 0. The first read of any address is therefore a miss.
- R2: A read accepted in `ST_IDLE` whose address is stored gives `resp_valid=1`, `resp_hit=1` and the stored word in the same cycle, and it raises no memory request.
- R3: A read that misses moves the block to `ST_FETCH` at the next edge. From that cycle until the acknowledge, `mem_req` is 1, `mem_addr` equals the missed address and `req_ready` is 0.
- R4: In the cycle where `mem_ack` is 1 during `ST_FETCH`, the outputs are `resp_valid=1`, `resp_hit=0` and `resp_data=mem_data`. The word is installed, and a later read of the same address hits with that word.
- R5: While the cache is not full, misses fill lines in ascending index order and the pointer stays 0. After N distinct misses, the next miss evicts the first address installed.
- R6: When a full cache misses, the line named by the pointer is overwritten and the pointer then advances by one modulo N. Evictions therefore follow install order.
- R7: A hit never moves the pointer. An address that is hit repeatedly is still the next one evicted if it was installed first.
- R8: `hit_count` and `miss_count` each increase by 1 per hit or per accepted miss, and each saturates at 2^CNT_W-1.
- R9: `cnt_clear=1` zeroes both counters at the next edge. It takes priority over a hit or miss that happens in the same cycle.
- R10: With 4 lines, the word-address loop 0x14, 0x11, 0x22, 0x14, 0x43, 0x12, 0x14, 0xAB, 0x33, started from an empty cache, gives 1 hit in pass one and 3 hits with 15 misses over passes two and three together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Word address of the read |
| req_ready | output | 1 | High in `ST_IDLE` when a request can be taken |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | Response came from the cache |
| resp_data | output | DATA_W | Returned word |
| mem_req | output | 1 | Memory fetch pending |
| mem_addr | output | ADDR_W | Address being fetched |
| mem_ack | input | 1 | Memory has the word on `mem_data` |
| mem_data | input | DATA_W | Fetched word |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| hit_count | output | CNT_W | Saturating hit tally |
| miss_count | output | CNT_W | Saturating miss tally |

## Verification
The hardest case to reach is a hit on the line that the pointer names. Only there does a design that wrongly moves the pointer on hits behave differently. The stimulus first fills every line, then hits the oldest address several times, then forces a miss and checks that the oldest address is the one that disappears. Full-pass address loops and a modulo sweep with fetch latencies of 0 to 3 cycles are compared against a first-in-first-out model in the bench. Saturation is reached with a narrow counter width in the bench configuration.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } fc_state_t;
endpackage

// File: rtl/fa_line_array.sv
module fa_line_array #(
    parameter int LINES  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [LINES-1:0]  line_vld;
    logic [ADDR_W-1:0] line_tag [LINES];
    logic [DATA_W-1:0] line_dat [LINES];
    logic [LINES-1:0]  match_vec;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_vld[g] <= 1'b0;
            end else if (sel) begin
                line_vld[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                line_tag[g] <= wr_addr;
                line_dat[g] <= wr_data;
            end
        end

        assign match_vec[g] = line_vld[g] && (line_tag[g] == lk_addr);
    end

    assign lk_hit = |match_vec;

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < LINES; i++) begin
            if (match_vec[i]) begin
                lk_data = lk_data | line_dat[i];
            end
        end
    end

    // R2: an address is never held in two lines at once
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));
endmodule

// File: rtl/fa_victim_sel.sv
module fa_victim_sel #(
    parameter int LINES = 4,
    parameter int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             install,
    output logic [IDX_W-1:0] victim
);
    localparam int FILL_W = IDX_W + 1;
    localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(LINES);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(LINES - 1);

    logic [FILL_W-1:0] fill_cnt;
    logic [IDX_W-1:0]  rr_ptr;
    logic              full;

    assign full   = (fill_cnt == FULL_CNT);
    assign victim = full ? rr_ptr : fill_cnt[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            rr_ptr   <= '0;
        end else if (install) begin
            if (!full) begin
                fill_cnt <= fill_cnt + 1'b1;
            end else if (rr_ptr == LAST_IDX) begin
                rr_ptr <= '0;
            end else begin
                rr_ptr <= rr_ptr + 1'b1;
            end
        end
    end

    // R7: without an install the pointer holds
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !install |=> $stable(rr_ptr));
    // R5: during the initial fill the pointer rests at line 0
    p_ptr_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt < FULL_CNT) |-> (rr_ptr == '0));
    // R6: an eviction moves the victim to a different line
    p_ptr_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (install && full) |=> (victim != $past(victim)));
endmodule

// File: rtl/fa_sat_counter.sv
module fa_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: a saturated counter stays saturated
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
    // R9: clear wins over any increment
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/fa_rr_cache.sv
module fa_rr_cache
    import fa_cache_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              cnt_clear,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    fc_state_t         state, state_nx;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic [IDX_W-1:0]  victim;
    logic [ADDR_W-1:0] pend_addr;
    logic              accept, hit_evt, miss_evt, install;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign hit_evt  = accept && lk_hit;
    assign miss_evt = accept && !lk_hit;
    assign install  = (state == ST_FETCH) && mem_ack;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (miss_evt) state_nx = ST_FETCH;
            ST_FETCH: if (mem_ack)  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
        end else if (miss_evt) begin
            pend_addr <= req_addr;
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        mem_req    = 1'b0;
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        resp_data  = '0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (hit_evt) begin
                    resp_valid = 1'b1;
                    resp_hit   = 1'b1;
                    resp_data  = lk_data;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    resp_valid = 1'b1;
                    resp_data  = mem_data;
                end
            end
            default: ;
        endcase
    end
    assign mem_addr = pend_addr;

    fa_line_array #(
        .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n),
        .lk_addr(req_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .wr_en(install), .wr_idx(victim), .wr_addr(pend_addr), .wr_data(mem_data)
    );

    fa_victim_sel #(.LINES(LINES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .install(install), .victim(victim)
    );

    fa_sat_counter #(.CNT_W(CNT_W)) u_hit_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(hit_evt), .cnt(hit_count)
    );

    fa_sat_counter #(.CNT_W(CNT_W)) u_miss_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(miss_evt), .cnt(miss_count)
    );

    // R3: the fetch request and its address hold until acknowledged
    p_fetch_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && !req_ready));
    // R4: an acknowledge produces a miss response in the same cycle
    p_ack_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |-> (resp_valid && !resp_hit && resp_data == mem_data));
    // R2: a hit response never coincides with a pending fetch
    p_hit_no_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (!mem_req && req_ready));
    // R3: an accepted miss leads to a fetch of that address
    p_miss_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !resp_hit) |=> (mem_req && mem_addr == $past(req_addr)));
endmodule

// File: tb/fa_rr_cache_tb.sv
module fa_rr_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINES  = 4;
    localparam int AW     = 16;
    localparam int DW     = 32;
    localparam int CW     = 6;
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, resp_valid, resp_hit, mem_req;
    logic [DW-1:0] resp_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_data = '0;
    logic          cnt_clear = 1'b0;
    logic [CW-1:0] hit_count, miss_count;

    int n_chk = 0;
    int n_err = 0;
    int lat   = 0;

    logic [AW-1:0] mdl_tag [LINES];
    int mdl_n = 0;
    int mdl_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fa_rr_cache #(.LINES(LINES), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_data(resp_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data), .cnt_clear(cnt_clear),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, a + 16'h0101};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_access(input logic [AW-1:0] a, output bit hit);
        hit = 1'b0;
        for (int i = 0; i < mdl_n; i++) if (mdl_tag[i] == a) hit = 1'b1;
        if (!hit) begin
            if (mdl_n < LINES) begin
                mdl_tag[mdl_n] = a;
                mdl_n++;
            end else begin
                mdl_tag[mdl_ptr] = a;
                mdl_ptr = (mdl_ptr + 1) % LINES;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        mem_ack = 1'b0;
        cnt_clear = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdl_n = 0;
        mdl_ptr = 0;
    endtask

    // one read; compares hit/miss with the FIFO model and checks the handshake
    task automatic access(input logic [AW-1:0] a, input string tag, output bit got_hit);
        bit exp_hit;
        model_access(a, exp_hit);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        got_hit = resp_valid && resp_hit;
        check(got_hit == exp_hit, tag, 32'(got_hit), 32'(exp_hit));
        if (got_hit) begin
            check(resp_data == mem_word(a), "R2 hit data", resp_data, mem_word(a));
            check(!mem_req, "R2 no fetch on hit", 32'(mem_req), 0);
        end else begin
            check(!resp_valid, "R3 no resp on miss", 32'(resp_valid), 0);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            check(mem_req && !req_ready && mem_addr == a, "R3 fetch addr",
                  32'(mem_addr), 32'(a));
            for (int k = 0; k < lat; k++) begin
                mem_data = ~mem_word(a);
                @(negedge clk);
                check(mem_req && mem_addr == a, "R3 fetch held", 32'(mem_req), 1);
            end
            mem_ack  = 1'b1;
            mem_data = mem_word(a);
            #1;
            check(resp_valid && !resp_hit && resp_data == mem_word(a), "R4 ack response",
                  resp_data, mem_word(a));
            @(negedge clk);
            mem_ack = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [AW-1:0] seq [9];
        bit h;
        int hits;
        int misses;
        seq[0] = 16'h14; seq[1] = 16'h11; seq[2] = 16'h22;
        seq[3] = 16'h14; seq[4] = 16'h43; seq[5] = 16'h12;
        seq[6] = 16'h14; seq[7] = 16'hAB; seq[8] = 16'h33;

        do_reset();
        #1;
        check(req_ready && !mem_req && !resp_valid, "R1 idle outputs", 32'(req_ready), 1);
        check(hit_count == 0 && miss_count == 0, "R1 counters", 32'(hit_count), 0);

        // R10 benchmark loop
        lat = 2;
        hits = 0;
        foreach (seq[i]) begin
            access(seq[i], "R10 pass1 model", h);
            hits += int'(h);
        end
        check(hits == 1, "R10 pass1 hits", hits, 1);
        hits = 0;
        misses = 0;
        for (int p = 0; p < 2; p++) begin
            foreach (seq[i]) begin
                access(seq[i], "R10 steady model", h);
                hits += int'(h);
                misses += int'(!h);
            end
        end
        check(hits == 3 && misses == 15, "R10 steady hits", hits, 3);
        check(hit_count == 4, "R8 hit tally", 32'(hit_count), 4);
        check(miss_count == 23, "R8 miss tally", 32'(miss_count), 23);

        // R5/R6/R7 directed eviction order
        do_reset();
        lat = 0;
        access(16'h0100, "R1 first miss", h);
        check(!h, "R1 empty misses", 32'(h), 0);
        for (int i = 1; i < LINES; i++) access(16'h0100 + 16'(i), "R5 fill", h);
        for (int i = 0; i < LINES; i++) begin
            access(16'h0100 + 16'(i), "R5 all resident", h);
            check(h, "R5 resident hit", 32'(h), 1);
        end
        repeat (3) access(16'h0100, "R7 hit oldest", h);
        access(16'h0200, "R6 evict", h);
        access(16'h0100, "R7 oldest evicted", h);
        check(!h, "R7 hits did not protect line 0", 32'(h), 0);
        access(16'h0102, "R6 line2 still resident", h);
        check(h, "R6 line2 kept", 32'(h), 1);
        access(16'h0101, "R6 line1 evicted", h);
        check(!h, "R6 second eviction", 32'(h), 0);

        // sweep over latencies with a modulo address walk
        for (int l = 0; l < 4; l++) begin
            lat = l;
            do_reset();
            hits = 0;
            misses = 0;
            for (int i = 0; i < 30; i++) begin
                access(16'h0300 + 16'((i * 7 + l) % 6), "R6 sweep model", h);
                hits += int'(h);
                misses += int'(!h);
            end
            #1;
            check(hit_count == CW'(hits), "R8 sweep hits", 32'(hit_count), hits);
            check(miss_count == CW'(misses), "R8 sweep misses", 32'(miss_count), misses);
        end

        // R9 clear has priority over a simultaneous hit
        do_reset();
        lat = 0;
        access(16'h0040, "R9 prime", h);
        access(16'h0040, "R9 prime hit", h);
        @(negedge clk);
        cnt_clear = 1'b1;
        req_valid = 1'b1;
        req_addr  = 16'h0040;
        @(negedge clk);
        cnt_clear = 1'b0;
        req_valid = 1'b0;
        #1;
        check(hit_count == 0 && miss_count == 0, "R9 clear priority", 32'(hit_count), 0);

        // R8 saturation
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_addr  = 16'h0040;
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(hit_count == CMAX, "R8 saturation", 32'(hit_count), 32'(CMAX));
        check(miss_count == 0, "R8 miss untouched", 32'(miss_count), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule